// File: doc/BRIEF.md
# Synchronous Exception Entry Controller

This block takes a processor core into an exception handler in one clock. The core raises a one-cycle request with the cause code, the trap value, the PC of the faulting instruction, a flag that marks a 16-bit (compressed) instruction, and its current privilege level. On the next clock edge the block saves the faulting PC, the cause and the trap value into the target level's registers. It updates the shared status word and moves the privilege level. It also drives a redirect strobe together with the handler address that the fetch unit must load.

The target level depends only on the privilege the core was running at. User and supervisor traps go to supervisor. Machine traps stay in machine. The handler address comes from that level's trap-vector register, which holds a base address and a mode. There are two modes: a direct jump to the base, or a per-cause slot four bytes apart. A machine trap taken while the machine vector is still zero does not vector. It resumes execution just past the faulting instruction. A small register port, with a one-cycle write and a combinational read, lets software set the vector and status registers and read back the saved state.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the privilege output is machine (code 3), the redirect PC is zero, the redirect strobe is low, and every register reads zero through the port.
- R2: A request while the current privilege is user (0) or supervisor (1) sets the privilege output to supervisor (1) and loads the supervisor saved-PC (0x141), cause (0x142) and trap value (0x143) with the faulting PC, the cause and the trap value.
- R3: On a supervisor-level entry the status word copies its bit 1 (supervisor interrupt enable) into bit 5, clears bit 1, and writes bit 8 with bit 0 of the prior privilege code; no other status bit changes.
- R4: A request while the current privilege is machine (3) keeps the privilege at 3, loads the machine saved-PC (0x341), cause (0x342) and trap value (0x343), copies status bit 3 into bit 7, clears bit 3 and writes the prior privilege code into bits 12:11.
- R5: With vector mode 0 (vector bits 1:0) the redirect PC equals the vector register with bits 1:0 cleared. The machine vector is at 0x305 and the supervisor vector at 0x105.
- R6: With vector mode 1 the redirect PC equals the cleared base plus four times the cause with bit 31 forced to zero.
- R7: Vector modes 2 and 3 give the same redirect PC as mode 0.
- R8: A machine-level request while the machine vector register is zero sets the redirect PC and the machine saved-PC to the faulting PC plus 2 when the compressed flag is high, or plus 4 otherwise. The cause and trap value are still loaded.
- R9: A register write that arrives in the same cycle as a request is dropped; the register keeps its old value, and the request uses that old value.
- R10: The status word is at 0x300. A restricted view at 0x100 reads only bits 1, 5 and 8, and a write there changes only those bits.
- R11: The redirect strobe is high for exactly the one cycle after each request, and the redirect PC holds its value whenever the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excValid | input | 1 | One-cycle exception request |
| excCause | input | XLEN | Cause code of the exception |
| excTval | input | XLEN | Trap value supplied by the core |
| excPc | input | XLEN | PC of the faulting instruction |
| excCompressed | input | 1 | Faulting instruction is 16 bits |
| curPriv | input | 2 | Privilege at the time of the fault (0 U, 1 S, 3 M) |
| csrWe | input | 1 | Register write strobe |
| csrAddr | input | CSR_AW | Register address for read and write |
| csrWdata | input | XLEN | Register write data |
| csrRdata | output | XLEN | Register read data for csrAddr |
| redirectValid | output | 1 | Handler address valid this cycle |
| pcOut | output | XLEN | Handler address, or resume address |
| privOut | output | 2 | Privilege after the last entry |

## Verification
The properties assume that the core reports the reserved privilege code 2 only as a non-machine level, and that the vector registers change only through the register port. The stimulus drives only the codes 0, 1 and 3. It loads the vectors with separate writes placed away from requests, except in the one collision case, which checks R9 at the port. Requests arrive on separate cycles with idle cycles between them, so each redirect has exactly one queued expectation.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } privT;

  // strobes from control to datapath
  typedef struct packed {
    logic takeS;     // enter supervisor level
    logic takeM;     // enter machine level
    logic skipFault; // machine vector unset: resume past fault
    logic vecSlot;   // per-cause slot addressing
    logic csrWrEn;   // software write allowed this cycle
  } trapStrobeT;

  // status bit positions
  localparam int SIE_BIT  = 1;
  localparam int MIE_BIT  = 3;
  localparam int SPIE_BIT = 5;
  localparam int MPIE_BIT = 7;
  localparam int SPP_BIT  = 8;
  localparam int MPP_LO   = 11;
  localparam int MPP_HI   = 12;

  // register addresses
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_STVEC   = 12'h105;
  localparam logic [11:0] A_SEPC    = 12'h141;
  localparam logic [11:0] A_SCAUSE  = 12'h142;
  localparam logic [11:0] A_STVAL   = 12'h143;
  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_MEPC    = 12'h341;
  localparam logic [11:0] A_MCAUSE  = 12'h342;
  localparam logic [11:0] A_MTVAL   = 12'h343;

  localparam logic [1:0] VMODE_SLOT = 2'd1;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            excValid,
  input  logic [1:0]      curPriv,
  input  logic            csrWe,
  input  logic [XLEN-1:0] mtvecVal,
  input  logic [XLEN-1:0] stvecVal,
  output trapStrobeT      strb
);

  logic  fromMachine;
  logic  mVecUnset;
  logic [1:0] selMode;

  assign fromMachine = (privT'(curPriv) == PRIV_M);
  assign mVecUnset   = (mtvecVal == '0);
  assign selMode     = fromMachine ? mtvecVal[1:0] : stvecVal[1:0];

  always_comb begin
    strb           = '0;
    strb.takeS     = excValid && !fromMachine;
    strb.takeM     = excValid && fromMachine;
    strb.skipFault = excValid && fromMachine && mVecUnset;
    // modes 2 and 3 fall through to direct
    strb.vecSlot   = excValid && !strb.skipFault && (selMode == VMODE_SLOT);
    // a request in the same cycle wins over software
    strb.csrWrEn   = csrWe && !excValid;
  end

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CSR_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobeT        strb,
  input  logic [XLEN-1:0]   excCause,
  input  logic [XLEN-1:0]   excTval,
  input  logic [XLEN-1:0]   excPc,
  input  logic              excCompressed,
  input  logic [1:0]        curPriv,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic [XLEN-1:0]   mtvecVal,
  output logic [XLEN-1:0]   stvecVal,
  output logic              redirectValid,
  output logic [XLEN-1:0]   pcOut,
  output logic [1:0]        privOut
);

  localparam logic [XLEN-1:0] CAUSE_KEEP = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] S_VIEW =
    (XLEN'(1) << SIE_BIT) | (XLEN'(1) << SPIE_BIT) | (XLEN'(1) << SPP_BIT);

  logic [XLEN-1:0] statusQ, mtvecQ, stvecQ;
  logic [XLEN-1:0] mepcQ, mcauseQ, mtvalQ;
  logic [XLEN-1:0] sepcQ, scauseQ, stvalQ;

  logic [XLEN-1:0] stepPc, selVec, baseAddr, causeIdx, slotOff, targetPc;
  logic [XLEN-1:0] statusEnter;
  logic            takeAny;

  assign mtvecVal = mtvecQ;
  assign stvecVal = stvecQ;
  assign takeAny  = strb.takeS | strb.takeM;

  // handler address
  always_comb begin
    stepPc   = excPc + (excCompressed ? XLEN'(2) : XLEN'(4));
    selVec   = strb.takeS ? stvecQ : mtvecQ;
    baseAddr = {selVec[XLEN-1:2], 2'b00};
    causeIdx = excCause & CAUSE_KEEP;
    slotOff  = {causeIdx[XLEN-3:0], 2'b00};
    if (strb.skipFault)     targetPc = stepPc;
    else if (strb.vecSlot)  targetPc = baseAddr + slotOff;
    else                    targetPc = baseAddr;
  end

  // status word on entry
  always_comb begin
    statusEnter = statusQ;
    if (strb.takeS) begin
      statusEnter[SPIE_BIT] = statusQ[SIE_BIT];
      statusEnter[SIE_BIT]  = 1'b0;
      statusEnter[SPP_BIT]  = curPriv[0];
    end else if (strb.takeM) begin
      statusEnter[MPIE_BIT]          = statusQ[MIE_BIT];
      statusEnter[MIE_BIT]           = 1'b0;
      statusEnter[MPP_HI:MPP_LO]     = curPriv;
    end
  end

  // register read
  always_comb begin
    case (csrAddr)
      CSR_AW'(A_SSTATUS): csrRdata = statusQ & S_VIEW;
      CSR_AW'(A_STVEC):   csrRdata = stvecQ;
      CSR_AW'(A_SEPC):    csrRdata = sepcQ;
      CSR_AW'(A_SCAUSE):  csrRdata = scauseQ;
      CSR_AW'(A_STVAL):   csrRdata = stvalQ;
      CSR_AW'(A_MSTATUS): csrRdata = statusQ;
      CSR_AW'(A_MTVEC):   csrRdata = mtvecQ;
      CSR_AW'(A_MEPC):    csrRdata = mepcQ;
      CSR_AW'(A_MCAUSE):  csrRdata = mcauseQ;
      CSR_AW'(A_MTVAL):   csrRdata = mtvalQ;
      default:            csrRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ       <= '0;
      mtvecQ        <= '0;
      stvecQ        <= '0;
      mepcQ         <= '0;
      mcauseQ       <= '0;
      mtvalQ        <= '0;
      sepcQ         <= '0;
      scauseQ       <= '0;
      stvalQ        <= '0;
      pcOut         <= '0;
      privOut       <= PRIV_M;
      redirectValid <= 1'b0;
    end else begin
      redirectValid <= takeAny;
      if (takeAny) begin
        statusQ <= statusEnter;
        pcOut   <= targetPc;
      end
      if (strb.takeS) begin
        privOut <= PRIV_S;
        sepcQ   <= excPc;
        scauseQ <= excCause;
        stvalQ  <= excTval;
      end
      if (strb.takeM) begin
        privOut <= PRIV_M;
        mepcQ   <= strb.skipFault ? stepPc : excPc;
        mcauseQ <= excCause;
        mtvalQ  <= excTval;
      end
      if (strb.csrWrEn) begin
        case (csrAddr)
          CSR_AW'(A_SSTATUS): statusQ <= (statusQ & ~S_VIEW) | (csrWdata & S_VIEW);
          CSR_AW'(A_STVEC):   stvecQ  <= csrWdata;
          CSR_AW'(A_SEPC):    sepcQ   <= csrWdata;
          CSR_AW'(A_SCAUSE):  scauseQ <= csrWdata;
          CSR_AW'(A_STVAL):   stvalQ  <= csrWdata;
          CSR_AW'(A_MSTATUS): statusQ <= csrWdata;
          CSR_AW'(A_MTVEC):   mtvecQ  <= csrWdata;
          CSR_AW'(A_MEPC):    mepcQ   <= csrWdata;
          CSR_AW'(A_MCAUSE):  mcauseQ <= csrWdata;
          CSR_AW'(A_MTVAL):   mtvalQ  <= csrWdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CSR_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [XLEN-1:0]   excCause,
  input  logic [XLEN-1:0]   excTval,
  input  logic [XLEN-1:0]   excPc,
  input  logic              excCompressed,
  input  logic [1:0]        curPriv,
  input  logic              csrWe,
  input  logic [CSR_AW-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              redirectValid,
  output logic [XLEN-1:0]   pcOut,
  output logic [1:0]        privOut
);

  trapStrobeT      strb;
  logic [XLEN-1:0] mtvecVal;
  logic [XLEN-1:0] stvecVal;

  trap_ctrl #(.XLEN(XLEN)) u_ctrl (
    .excValid (excValid),
    .curPriv  (curPriv),
    .csrWe    (csrWe),
    .mtvecVal (mtvecVal),
    .stvecVal (stvecVal),
    .strb     (strb)
  );

  trap_dp #(.XLEN(XLEN), .CSR_AW(CSR_AW)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .excCause      (excCause),
    .excTval       (excTval),
    .excPc         (excPc),
    .excCompressed (excCompressed),
    .curPriv       (curPriv),
    .csrAddr       (csrAddr),
    .csrWdata      (csrWdata),
    .csrRdata      (csrRdata),
    .mtvecVal      (mtvecVal),
    .stvecVal      (stvecVal),
    .redirectValid (redirectValid),
    .pcOut         (pcOut),
    .privOut       (privOut)
  );

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            excValid,
  input logic [1:0]      curPriv,
  input logic [XLEN-1:0] excPc,
  input logic            excCompressed,
  input logic [XLEN-1:0] mtvecVal,
  input logic            redirectValid,
  input logic [XLEN-1:0] pcOut,
  input logic [1:0]      privOut
);

  // R11
  strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> redirectValid);

  // R11
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(excValid));

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |-> $stable(pcOut));

  // R2
  lower_to_super_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && curPriv != 2'd3) |=> (privOut == 2'd1));

  // R4
  machine_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && curPriv == 2'd3) |=> (privOut == 2'd3));

  // R5
  direct_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && curPriv == 2'd3 && mtvecVal != '0 && mtvecVal[1:0] == 2'd0)
      |=> (pcOut == {$past(mtvecVal[XLEN-1:2]), 2'b00}));

  // R8
  skip_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && curPriv == 2'd3 && mtvecVal == '0)
      |=> (pcOut == $past(excPc) + ($past(excCompressed) ? XLEN'(2) : XLEN'(4))));

endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .excValid      (excValid),
  .curPriv       (curPriv),
  .excPc         (excPc),
  .excCompressed (excCompressed),
  .mtvecVal      (mtvecVal),
  .redirectValid (redirectValid),
  .pcOut         (pcOut),
  .privOut       (privOut)
);

// File: tb/trap_entry_ctrl_tb.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [31:0] excCause = '0, excTval = '0, excPc = '0;
  logic        excCompressed = 1'b0;
  logic [1:0]  curPriv = 2'd3;
  logic        csrWe = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata, pcOut;
  logic        redirectValid;
  logic [1:0]  privOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trap_entry_ctrl u_dut (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCause(excCause),
    .excTval(excTval), .excPc(excPc), .excCompressed(excCompressed),
    .curPriv(curPriv), .csrWe(csrWe), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .redirectValid(redirectValid), .pcOut(pcOut),
    .privOut(privOut)
  );

  typedef struct {
    logic [31:0] pc;
    logic [1:0]  priv;
    string       req;
  } expT;
  expT sbQ[$];

  // bench model of register contents
  logic [31:0] mStatus = 0, mTvec = 0, sTvec = 0;
  logic [31:0] mEpc = 0, mCause = 0, mTval = 0, sEpc = 0, sCause = 0, sTval = 0;
  logic [31:0] lastPc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pop and compare on every redirect
  always @(negedge clk) begin
    if (rstN && redirectValid) begin
      if (sbQ.size() == 0) chk("R11 unexpected redirect", 32'd1, 32'd0);
      else begin
        expT e;
        e = sbQ.pop_front();
        chk({e.req, " pc"}, pcOut, e.pc);
        chk({e.req, " priv"}, {30'd0, privOut}, {30'd0, e.priv});
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    csrAddr = a;
    #1;
    chk(req, csrRdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrWe = 1'b1; csrAddr = a; csrWdata = d;
    @(negedge clk);
    csrWe = 1'b0;
    case (a)
      12'h300: mStatus = d;
      12'h100: mStatus = (mStatus & ~32'h122) | (d & 32'h122);
      12'h305: mTvec = d;
      12'h105: sTvec = d;
      default: ;
    endcase
  endtask

  // driver: apply one request, push the expected redirect
  task automatic doTrap(input logic [1:0] pr, input logic [31:0] pc, input bit comp,
                        input logic [31:0] cause, input logic [31:0] tval,
                        input string req, input bit withWr = 0,
                        input logic [11:0] wa = 0, input logic [31:0] wd = 0);
    expT e;
    logic [31:0] tv, base, np;
    tv = (pr == 2'd3) ? mTvec : sTvec;
    base = tv & ~32'h3;
    if (pr == 2'd3 && mTvec == 0) np = pc + (comp ? 32'd2 : 32'd4);
    else if (tv[1:0] == 2'd1) np = base + ((cause & 32'h7fffffff) << 2);
    else np = base;
    if (pr == 2'd3) begin
      mStatus[7] = mStatus[3]; mStatus[3] = 1'b0; mStatus[12:11] = pr;
      mEpc = (mTvec == 0) ? np : pc; mCause = cause; mTval = tval;
      e.priv = 2'd3;
    end else begin
      mStatus[5] = mStatus[1]; mStatus[1] = 1'b0; mStatus[8] = pr[0];
      sEpc = pc; sCause = cause; sTval = tval;
      e.priv = 2'd1;
    end
    e.pc = np; e.req = req;
    @(negedge clk);
    curPriv = pr; excPc = pc; excCompressed = comp; excCause = cause; excTval = tval;
    excValid = 1'b1;
    if (withWr) begin csrWe = 1'b1; csrAddr = wa; csrWdata = wd; end
    sbQ.push_back(e);
    @(negedge clk);
    excValid = 1'b0; csrWe = 1'b0;
    lastPc = np;
    @(negedge clk);
    chk("R11 strobe low", {31'd0, redirectValid}, 32'd0);
    chk("R11 pc held", pcOut, lastPc);
  endtask

  task automatic checkAll(input string req);
    rd(12'h300, mStatus, {req, " status"});
    rd(12'h341, mEpc, {req, " mepc"});
    rd(12'h342, mCause, {req, " mcause"});
    rd(12'h343, mTval, {req, " mtval"});
    rd(12'h141, sEpc, {req, " sepc"});
    rd(12'h142, sCause, {req, " scause"});
    rd(12'h143, sTval, {req, " stval"});
  endtask

  initial begin
    #150000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 priv", {30'd0, privOut}, 32'd3);
    chk("R1 pc", pcOut, 32'd0);
    chk("R1 strobe", {31'd0, redirectValid}, 32'd0);
    rstN = 1'b1;
    rd(12'h305, 0, "R1 mtvec");
    rd(12'h105, 0, "R1 stvec");
    checkAll("R1");

    // R8 machine vector unset: skip by 4 and by 2
    doTrap(2'd3, 32'h100, 0, 32'd2, 32'hdeadbeef, "R8 skip4");
    checkAll("R8");
    doTrap(2'd3, 32'h200, 1, 32'd3, 32'h200, "R8 skip2");
    checkAll("R8");

    // R4 R5 machine entry, direct mode
    wr(12'h300, 32'h8);
    wr(12'h305, 32'h1000);
    doTrap(2'd3, 32'h300, 0, 32'd4, 32'h333, "R5 direct");
    checkAll("R4");

    // R6 per-cause slots, bit 31 dropped
    wr(12'h305, 32'h2001);
    doTrap(2'd3, 32'h400, 0, 32'd11, 32'h0, "R6 slot");
    doTrap(2'd3, 32'h404, 0, 32'h80000003, 32'h0, "R6 msb");
    checkAll("R6");

    // R7 reserved modes behave as direct
    wr(12'h305, 32'h3002);
    doTrap(2'd3, 32'h410, 0, 32'd6, 32'h7, "R7 mode2");
    wr(12'h305, 32'h3003);
    doTrap(2'd3, 32'h414, 0, 32'd6, 32'h7, "R7 mode3");

    // R2 R3 supervisor entry from user, then from supervisor
    wr(12'h105, 32'h4001);
    wr(12'h300, 32'h2);
    doTrap(2'd0, 32'h500, 0, 32'd6, 32'h555, "R2 from U");
    checkAll("R3 from U");
    rd(12'h100, 32'h20, "R3 sview");
    wr(12'h105, 32'h4000);
    doTrap(2'd1, 32'h600, 1, 32'd2, 32'h13, "R2 from S");
    checkAll("R3 from S");

    // R10 restricted status view
    wr(12'h100, 32'hffffffff);
    rd(12'h300, mStatus, "R10 write view");
    rd(12'h100, 32'h122, "R10 read view");
    wr(12'h300, 32'h1888);
    wr(12'h100, 32'h0);
    rd(12'h300, 32'h1888, "R10 other bits kept");

    // R9 write in the same cycle as a request is dropped
    doTrap(2'd3, 32'h700, 0, 32'd3, 32'h700, "R9 collide", 1, 12'h305, 32'h9999);
    rd(12'h305, 32'h3003, "R9 mtvec kept");
    checkAll("R9");

    repeat (3) @(negedge clk);
    chk("R11 queue drained", sbQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule